// File: doc/BRIEF.md
# Video Memory Access Arbiter

This block decides, on every character clock, whether a single-ported video memory serves the CRT display fetch or a CPU read/write cycle. A CPU cycle that selects video memory while the display is busy is held off through the CPU's active-low WAIT. The hold lasts until the display fetch ends. Only then is the CPU cycle granted, and it keeps the memory until the CPU drops its strobe.

The display controller's enable pin is used as a look-ahead. The controller is programmed to start each line one character address early. The enable that gates video is a copy of the pin delayed by one character clock, made inside this block. For that one character before a line starts, the raw pin is already high while the delayed enable is still low. The block uses that character to refuse a CPU access that would run into the next line fetch. This prevents both a corrupted CPU cycle and interference along the left edge of the picture.

The block also drives the address multiplexer. The display address goes to the memory whenever the delayed enable is high. The CPU address goes to the memory at all other times.

Top module: `vram_arbiter`

## Requirements
- R1: While rst_ni is low, and after reset with no CPU request, wait_no is 1, cpu_grant_o is 0 and de_video_o is 0.
- R2: de_video_o equals the value de_raw_i had one character clock earlier.
- R3: mux_disp_o equals de_video_o. mem_addr_o equals disp_addr_i when de_video_o is 1, and cpu_addr_i when it is 0.
- R4: When a CPU request (cpu_sel_i going high from idle) arrives while de_video_o is 1, wait_no is 0 in that same cycle.
- R5: When a CPU request arrives while de_raw_i is 1 and de_video_o is still 0 (a line is about to start), wait_no is 0 in that same cycle.
- R6: When a CPU request arrives while de_raw_i and de_video_o are both 0, wait_no stays 1, and cpu_grant_o is 1 from the next cycle on.
- R7: A waiting request keeps wait_no at 0 until a clock edge at which de_raw_i and de_video_o are both 0. In the cycle after that edge, wait_no is 1 and cpu_grant_o is 1.
- R8: Once granted, cpu_grant_o stays 1 while cpu_sel_i is 1, even if the enables rise. It falls in the cycle after cpu_sel_i is sampled low.
- R9: wait_no is 1 whenever cpu_sel_i is 0, including when a waiting request is withdrawn. A withdrawn request returns the arbiter to idle with no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_raw_i | input | 1 | Undelayed display enable from the CRT controller |
| cpu_sel_i | input | 1 | CPU strobe qualified by video memory address decode |
| cpu_addr_i | input | ADDR_W | CPU address |
| disp_addr_i | input | ADDR_W | Display refresh address from the CRT controller |
| de_video_o | output | 1 | Delayed display enable used for video |
| wait_no | output | 1 | CPU WAIT, active low |
| cpu_grant_o | output | 1 | CPU cycle currently owns the memory |
| mux_disp_o | output | 1 | Address mux select, 1 = display address |
| mem_addr_o | output | ADDR_W | Address presented to video memory |

## Verification
Requests are issued under three enable patterns. The first is the middle of an active line, with both enables high. The second is the one-character look-ahead gap, where the raw enable is high and the delayed enable is low. The third is the blanking interval, with both enables low. These patterns separate the plain busy stall from the early line-start stall and from an immediate grant. A waiting request is carried across the trailing edge of a line, where the raw enable has fallen and the delayed enable is still high, to show that release waits for both. A granted request is held across a new line start to show it keeps ownership. A request withdrawn while waiting shows WAIT follows the strobe and no grant is left behind.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2
  } acc_state_e;
endpackage

// File: rtl/de_delay.sv
module de_delay #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic de_raw_i,
  output logic de_dly_o,
  output logic busy_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= de_raw_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign de_dly_o = chain_q[STAGES-1];
  // any stage high: display fetch active or about to begin
  assign busy_o   = de_raw_i | (|chain_q);
endmodule

// File: rtl/access_fsm.sv
module access_fsm
  import vram_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic busy_i,
  output logic wait_no,
  output logic grant_o
);
  acc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (sel_i) state_d = busy_i ? ST_WAIT : ST_GRANT;
      ST_WAIT:  if (!sel_i) state_d = ST_IDLE;
                else if (!busy_i) state_d = ST_GRANT;
      ST_GRANT: if (!sel_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  logic stall;
  assign stall   = sel_i & (((state_q == ST_IDLE) & busy_i) | (state_q == ST_WAIT));
  assign wait_no = ~stall;
  assign grant_o = (state_q == ST_GRANT);
endmodule

// File: rtl/addr_mux.sv
module addr_mux #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              disp_sel_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = disp_sel_i ? disp_addr_i : cpu_addr_i;
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter #(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned DE_DELAY = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_raw_i,
  input  logic              cpu_sel_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic              de_video_o,
  output logic              wait_no,
  output logic              cpu_grant_o,
  output logic              mux_disp_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic de_dly, busy;

  de_delay #(.STAGES(DE_DELAY)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .de_raw_i (de_raw_i),
    .de_dly_o (de_dly),
    .busy_o   (busy)
  );

  access_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (cpu_sel_i),
    .busy_i  (busy),
    .wait_no (wait_no),
    .grant_o (cpu_grant_o)
  );

  addr_mux #(.ADDR_W(ADDR_W)) u_mux (
    .disp_sel_i  (de_dly),
    .cpu_addr_i  (cpu_addr_i),
    .disp_addr_i (disp_addr_i),
    .addr_o      (mem_addr_o)
  );

  assign de_video_o = de_dly;
  assign mux_disp_o = de_dly;
endmodule

// File: rtl/vram_arbiter_checker.sv
module vram_arbiter_checker #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              de_raw_i,
  input logic              cpu_sel_i,
  input logic [ADDR_W-1:0] disp_addr_i,
  input logic              de_video_o,
  input logic              wait_no,
  input logic              cpu_grant_o,
  input logic              mux_disp_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (de_video_o == $past(de_raw_i)));

  p_disp_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_video_o && mux_disp_o) |-> (mem_addr_o == disp_addr_i));

  p_busy_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_sel_i) && (de_raw_i || de_video_o)) |-> !wait_no);

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_no && !de_raw_i && !de_video_o) |=> wait_no);

  p_grant_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_grant_o && cpu_sel_i) |=> cpu_grant_o);

  p_idle_nowait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_sel_i |-> wait_no);

  p_grant_nowait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_grant_o |-> wait_no);
endmodule

bind vram_arbiter vram_arbiter_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .de_raw_i    (de_raw_i),
  .cpu_sel_i   (cpu_sel_i),
  .disp_addr_i (disp_addr_i),
  .de_video_o  (de_video_o),
  .wait_no     (wait_no),
  .cpu_grant_o (cpu_grant_o),
  .mux_disp_o  (mux_disp_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/vram_arbiter_bench.sv
module vram_arbiter_bench;
  localparam int unsigned ADDR_W = 14;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic de_raw = 1'b0;
  logic cpu_sel = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [ADDR_W-1:0] disp_addr = '0;
  logic de_video, wait_n, grant, mux_disp;
  logic [ADDR_W-1:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_arbiter #(.ADDR_W(ADDR_W)) u_vram_arbiter (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .de_raw_i    (de_raw),
    .cpu_sel_i   (cpu_sel),
    .cpu_addr_i  (cpu_addr),
    .disp_addr_i (disp_addr),
    .de_video_o  (de_video),
    .wait_no     (wait_n),
    .cpu_grant_o (grant),
    .mux_disp_o  (mux_disp),
    .mem_addr_o  (mem_addr)
  );

  typedef struct {
    logic              wait_n;
    logic              grant;
    logic              dv;
    logic [ADDR_W-1:0] addr;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic fail_line(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // driver: apply one cycle of stimulus and queue expected outputs
  task automatic step(input logic raw, input logic sel,
                      input logic e_wait_n, input logic e_grant, input logic e_dv,
                      input string req);
    exp_t e;
    @(negedge clk);
    de_raw    = raw;
    cpu_sel   = sel;
    cpu_addr  = cpu_addr + 14'h0111;
    disp_addr = disp_addr + 14'h0203;
    e.wait_n = e_wait_n;
    e.grant  = e_grant;
    e.dv     = e_dv;
    e.addr   = e_dv ? disp_addr : cpu_addr;
    e.req    = req;
    exp_q.push_back(e);
  endtask

  // monitor: compare after inputs settle, well before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (wait_n !== e.wait_n) fail_line(e.req, "wait_no", int'(wait_n), int'(e.wait_n));
        else if (grant !== e.grant) fail_line(e.req, "grant", int'(grant), int'(e.grant));
        else if (de_video !== e.dv) fail_line(e.req, "de_video", int'(de_video), int'(e.dv));
        else if (mux_disp !== e.dv) fail_line(e.req, "mux_disp", int'(mux_disp), int'(e.dv));
        else if (mem_addr !== e.addr) fail_line(e.req, "mem_addr", int'(mem_addr), int'(e.addr));
      end
    end
  end

  initial begin
    // R1: outputs during reset, with the raw enable high
    de_raw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (wait_n !== 1'b1 || grant !== 1'b0 || de_video !== 1'b0)
      fail_line("R1", "reset outputs", {wait_n, grant, de_video}, 3'b100);
    de_raw = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;

    //    raw  sel  wait_n grant dv
    step(0, 0, 1, 0, 0, "R1");
    step(1, 0, 1, 0, 0, "R2");
    step(1, 0, 1, 0, 1, "R2_R3");
    step(1, 1, 0, 0, 1, "R4");       // request in an active line
    step(1, 1, 0, 0, 1, "R4");
    step(0, 1, 0, 0, 1, "R7");       // raw low, delayed still high: keep waiting
    step(0, 1, 0, 0, 0, "R7");       // both low sampled at this edge
    step(0, 1, 1, 1, 0, "R7");       // released and granted
    step(1, 1, 1, 1, 0, "R8");       // line starts under a granted cycle
    step(1, 1, 1, 1, 1, "R8_R3");
    step(1, 0, 1, 1, 1, "R8");       // strobe low, grant falls next cycle
    step(0, 0, 1, 0, 1, "R8");
    step(0, 0, 1, 0, 0, "R9");
    step(1, 1, 0, 0, 0, "R5");       // look-ahead gap: raw high, delayed low
    step(0, 1, 0, 0, 1, "R5");
    step(0, 0, 1, 0, 0, "R9");       // withdrawn while waiting
    step(0, 0, 1, 0, 0, "R9");
    step(0, 1, 1, 0, 0, "R6");       // blanking: no stall
    step(0, 1, 1, 1, 0, "R6");
    step(0, 0, 1, 1, 0, "R8");
    step(0, 0, 1, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule